// File: doc/BRIEF.md
# Environment Save/Restore Stack Sequencer

This block owns the 64-bit stack pointer doubleword that backs the privileged environment save and restore operations. A save walks 28 consecutive stack words upward. It writes the 20 words that carry processor state, taking them from a register-file read port, and fills the 8 reserved words with zero. A restore walks the same 28 words downward and loads the 20 valid words back into the register file. The doubleword holds the stack address, a space counter, a word counter and their sticky overflow flags. Every access to a stack word moves these fields by one.

A restore first looks at the word counter. A count of at least 28 runs a normal restore. A count of zero asks the core to load the default status words instead. A count from 1 to 27 raises an instruction-exception trap with no side effects. A direct-write port replaces the whole doubleword while the block is idle. Decode, address translation and memory live outside the block. Memory is reached through a single-request valid/ready port.

Top module: `stk_env_seq`

## Requirements
- R1: While idle, `wr_en` loads all 64 bits of `wr_data` into `ptr_q` on the next clock. Layout: bits [16:0] stack address, bit 32 space overflow, bits [47:33] space count, bit 48 word overflow, bits [63:49] word count. `wr_en` is ignored while `busy` is high.
- R2: A save (`push_go`) makes exactly 28 write accesses. The accesses use addresses A+1 through A+28 in ascending order, modulo 2^17, where A is the starting address. The address field ends at A+28.
- R3: In a save, access j (0..27) is a valid position when bit j of mask 28'hF0FFFF0 is set. Its data is the register whose index is the number of mask ones below bit j. Reserved positions are written as zero.
- R4: A save adds 28 to the word count, modulo 2^15, and sets bit 48 if the count passes 32767. It subtracts 28 from the space count. It never traps, even when the space count reaches zero.
- R5: A restore with word count of 28 or more makes 28 reads, from address A down to A-27. The address field ends at A-28. Read k maps to position 27-k, and only valid positions write the register file (20 writes).
- R6: A normal restore subtracts 28 from the word count and adds 28 to the space count, modulo 2^15. It sets bit 32 if the space count passes 32767, and does not trap.
- R7: Bits 32 and 48 stay at 1 through any save or restore. Only a direct write clears them.
- R8: A restore with word count 0 pulses `dflt_psw_ld` and `done`, makes no access and leaves `ptr_q` unchanged.
- R9: A restore with word count from 1 to 27 pulses `trap_req` and `cc2_set` together with `done`. It makes no access, leaves `ptr_q` unchanged and presents `trap_vec` = 8'h4D.
- R10: `mem_req` stays high with stable address, direction and data until `mem_ready`. Each accepted cycle is one access. `busy` is high for the whole walk, and `done` pulses once per operation.
- R11: After reset, `ptr_q` is zero, `busy` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Direct write of the doubleword |
| wr_data | input | 64 | Value for direct write |
| push_go | input | 1 | Start a save |
| pull_go | input | 1 | Start a restore |
| ptr_q | output | 64 | Current stack pointer doubleword |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write (save), 0 = read (restore) |
| mem_addr | output | ADDR_W | Stack word address |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| rf_idx | output | IDX_W | Register-file index of the current position |
| rf_rdata | input | 32 | Register-file read data |
| rf_we | output | 1 | Register-file write strobe |
| rf_wdata | output | 32 | Register-file write data |
| dflt_psw_ld | output | 1 | Request to load the default status words |
| trap_req | output | 1 | Instruction-exception trap request |
| trap_vec | output | 8 | Trap vector |
| cc2_set | output | 1 | Set condition-code bit 2 |

## Verification
Save/restore round trips are tried at several starting addresses, including two that wrap the 17-bit address field. Each runs with memory always ready and with memory stalling every other cycle. The wrap cases show whether the address arithmetic is confined to its field, and the stalled runs show whether a held request is counted once. A sweep of word counts from 0 to 30 separates the three restore outcomes, and covers the 0/1 and 27/28 edges. Dedicated runs start near 32767 on each counter to tell a sticky flag from one that counting recomputes. A write poked in the middle of a save shows whether it is ignored.

// File: rtl/stk_env_pkg.sv
package stk_env_pkg;

    localparam int CNT_W   = 15;
    localparam int WORD_W  = 32;
    localparam int N_STEP  = 28;
    localparam int N_VALID = 20;
    localparam int POS_W   = $clog2(N_STEP);
    localparam int IDX_W   = $clog2(N_VALID);
    localparam logic [7:0] TRAP_VECTOR = 8'h4D;

    typedef enum logic [1:0] {ST_IDLE, ST_PUSH, ST_PULL} walk_st_e;
    typedef enum logic [1:0] {PG_RUN, PG_DFLT, PG_TRAP} pull_gate_e;

    // doubleword layout, MSB first
    typedef struct packed {
        logic [CNT_W-1:0]  wcnt;
        logic              wovf;
        logic [CNT_W-1:0]  scnt;
        logic              sovf;
        logic [WORD_W-1:0] low;
    } ptr_dw_t;

    // register index of a stack position: number of valid positions below it
    function automatic logic [IDX_W-1:0] slot_index(logic [N_STEP-1:0] mask, int pos);
        int cnt;
        cnt = 0;
        for (int i = 0; i < N_STEP; i++)
            if (i < pos && mask[i]) cnt++;
        return IDX_W'(cnt);
    endfunction

    function automatic pull_gate_e pull_gate(logic [CNT_W-1:0] wc);
        if (wc == '0)                  return PG_DFLT;
        else if (wc < CNT_W'(N_STEP))  return PG_TRAP;
        else                           return PG_RUN;
    endfunction

endpackage

// File: rtl/stk_ptr_reg.sv
module stk_ptr_reg
    import stk_env_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    ld_en,
    input  ptr_dw_t ld_val,
    input  logic    push_step,
    input  logic    pull_step,
    output ptr_dw_t dw_q
);

    ptr_dw_t nxt;
    logic    w_carry;
    logic    s_carry;

    always_comb begin
        nxt     = dw_q;
        w_carry = 1'b0;
        s_carry = 1'b0;
        if (push_step) begin
            nxt.low[ADDR_W-1:0] = dw_q.low[ADDR_W-1:0] + 1'b1;
            nxt.scnt            = dw_q.scnt - 1'b1;
            {w_carry, nxt.wcnt} = {1'b0, dw_q.wcnt} + 1'b1;
            nxt.wovf            = dw_q.wovf | w_carry;
        end else if (pull_step) begin
            nxt.low[ADDR_W-1:0] = dw_q.low[ADDR_W-1:0] - 1'b1;
            nxt.wcnt            = dw_q.wcnt - 1'b1;
            {s_carry, nxt.scnt} = {1'b0, dw_q.scnt} + 1'b1;
            nxt.sovf            = dw_q.sovf | s_carry;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        dw_q <= '0;
        else if (ld_en) dw_q <= ld_val;
        else            dw_q <= nxt;
    end

endmodule

// File: rtl/stk_walk_ctl.sv
module stk_walk_ctl
    import stk_env_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             push_go,
    input  logic             pull_go,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wcnt,
    input  logic             acc,
    output walk_st_e         st,
    output logic [POS_W-1:0] pos,
    output logic             dflt_pls,
    output logic             trap_pls,
    output logic             done_pls
);

    localparam logic [POS_W-1:0] LAST_POS = POS_W'(N_STEP - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            pos      <= '0;
            dflt_pls <= 1'b0;
            trap_pls <= 1'b0;
            done_pls <= 1'b0;
        end else begin
            dflt_pls <= 1'b0;
            trap_pls <= 1'b0;
            done_pls <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (!wr_en && push_go) begin
                        st  <= ST_PUSH;
                        pos <= '0;
                    end else if (!wr_en && pull_go) begin
                        case (pull_gate(wcnt))
                            PG_RUN: begin
                                st  <= ST_PULL;
                                pos <= '0;
                            end
                            PG_DFLT: begin
                                dflt_pls <= 1'b1;
                                done_pls <= 1'b1;
                            end
                            default: begin
                                trap_pls <= 1'b1;
                                done_pls <= 1'b1;
                            end
                        endcase
                    end
                end
                default: begin
                    if (acc) begin
                        if (pos == LAST_POS) begin
                            st       <= ST_IDLE;
                            done_pls <= 1'b1;
                        end else begin
                            pos <= pos + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/stk_env_seq.sv
module stk_env_seq
    import stk_env_pkg::*;
#(
    parameter int                ADDR_W     = 17,
    parameter logic [N_STEP-1:0] VALID_MASK = 28'hF0FFFF0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [63:0]       wr_data,
    input  logic              push_go,
    input  logic              pull_go,
    output logic [63:0]       ptr_q,
    output logic              busy,
    output logic              done,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [IDX_W-1:0]  rf_idx,
    input  logic [WORD_W-1:0] rf_rdata,
    output logic              rf_we,
    output logic [WORD_W-1:0] rf_wdata,
    output logic              dflt_psw_ld,
    output logic              trap_req,
    output logic [7:0]        trap_vec,
    output logic              cc2_set
);

    walk_st_e         st;
    logic [POS_W-1:0] pos;
    logic [POS_W-1:0] phys;
    logic             acc;
    logic             idle;
    logic             trap_pls;
    ptr_dw_t          dw_q;
    logic [IDX_W-1:0] slot_tab [N_STEP];
    logic [ADDR_W-1:0] tsa;

    for (genvar g = 0; g < N_STEP; g++) begin : g_slot
        assign slot_tab[g] = slot_index(VALID_MASK, g);
    end

    assign idle = (st == ST_IDLE);
    assign acc  = mem_req & mem_ready;
    assign tsa  = dw_q.low[ADDR_W-1:0];

    // a restore visits positions from the top down
    assign phys = (st == ST_PULL) ? (POS_W'(N_STEP - 1) - pos) : pos;

    stk_walk_ctl u_ctl (
        .clk      (clk),
        .rst      (rst),
        .push_go  (push_go),
        .pull_go  (pull_go),
        .wr_en    (wr_en),
        .wcnt     (dw_q.wcnt),
        .acc      (acc),
        .st       (st),
        .pos      (pos),
        .dflt_pls (dflt_psw_ld),
        .trap_pls (trap_pls),
        .done_pls (done)
    );

    stk_ptr_reg #(.ADDR_W(ADDR_W)) u_ptr (
        .clk       (clk),
        .rst       (rst),
        .ld_en     (wr_en & idle),
        .ld_val    (ptr_dw_t'(wr_data)),
        .push_step (acc & (st == ST_PUSH)),
        .pull_step (acc & (st == ST_PULL)),
        .dw_q      (dw_q)
    );

    assign ptr_q     = dw_q;
    assign busy      = ~idle;
    assign mem_req   = ~idle;
    assign mem_we    = (st == ST_PUSH);
    assign mem_addr  = mem_we ? tsa + 1'b1 : tsa;
    assign rf_idx    = slot_tab[phys];
    assign mem_wdata = VALID_MASK[phys] ? rf_rdata : '0;
    assign rf_we     = acc & (st == ST_PULL) & VALID_MASK[phys];
    assign rf_wdata  = mem_rdata;
    assign trap_req  = trap_pls;
    assign cc2_set   = trap_pls;
    assign trap_vec  = TRAP_VECTOR;

endmodule

// File: rtl/stk_env_seq_chk.sv
module stk_env_seq_chk
    import stk_env_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [63:0]       ptr_q,
    input logic              busy,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [WORD_W-1:0] mem_wdata,
    input logic              mem_ready,
    input logic              rf_we,
    input logic              dflt_psw_ld,
    input logic              trap_req
);

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    // R10
    req_busy_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy);

    // R2
    push_addr_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_ready && mem_we |=> ptr_q[ADDR_W-1:0] == $past(mem_addr));

    // R5
    pull_addr_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_ready && !mem_we |=> ptr_q[ADDR_W-1:0] == ADDR_W'($past(mem_addr) - 1'b1));

    // R5
    rf_load_chk: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> mem_req && mem_ready && !mem_we);

    // R7
    wovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ptr_q[48] && !wr_en |=> ptr_q[48]);

    // R7
    sovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ptr_q[32] && !wr_en |=> ptr_q[32]);

    // R9
    trap_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        trap_req |-> !busy && $stable(ptr_q));

    // R8
    dflt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        dflt_psw_ld |-> !busy && $stable(ptr_q) && $onehot0({dflt_psw_ld, trap_req}));

endmodule

bind stk_env_seq stk_env_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .ptr_q       (ptr_q),
    .busy        (busy),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_ready   (mem_ready),
    .rf_we       (rf_we),
    .dflt_psw_ld (dflt_psw_ld),
    .trap_req    (trap_req)
);

// File: tb/sim_stk_env_seq.sv
module sim_stk_env_seq;

    localparam int AW = 17;
    localparam int AMASK = (1 << AW) - 1;
    localparam logic [27:0] BMASK = 28'hF0FFFF0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [63:0] wr_data = '0;
    logic        push_go = 1'b0;
    logic        pull_go = 1'b0;
    logic [63:0] ptr_q;
    logic        busy, done, mem_req, mem_we, rf_we, dflt_psw_ld, trap_req, cc2_set;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata, rf_rdata, rf_wdata;
    logic        mem_ready;
    logic [4:0]  rf_idx;
    logic [7:0]  trap_vec;

    logic [31:0] mem [0:511];
    logic [31:0] rf  [0:31];
    int          acc_addr [0:63];
    int n_acc = 0, n_rfw = 0, n_done = 0, n_dflt = 0, n_trap = 0, n_cc2 = 0;
    logic        stall = 1'b0;
    logic        rdy_tog = 1'b0;
    logic        fill_en = 1'b0;
    logic [23:0] fill_seed = '0;
    int checks = 0, failures = 0;
    bit wd = 0;

    always #5 clk = ~clk;

    assign mem_ready = stall ? rdy_tog : 1'b1;
    assign mem_rdata = mem[mem_addr[8:0]];
    assign rf_rdata  = rf[rf_idx];

    stk_env_seq u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .push_go(push_go), .pull_go(pull_go), .ptr_q(ptr_q), .busy(busy), .done(done),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata), .rf_idx(rf_idx), .rf_rdata(rf_rdata),
        .rf_we(rf_we), .rf_wdata(rf_wdata), .dflt_psw_ld(dflt_psw_ld), .trap_req(trap_req),
        .trap_vec(trap_vec), .cc2_set(cc2_set)
    );

    function automatic logic [31:0] fval(int i, logic [23:0] s);
        return {s, 8'(i + 1)};
    endfunction

    function automatic int bslot(int j);
        int c = 0;
        for (int i = 0; i < j; i++) if (BMASK[i]) c++;
        return c;
    endfunction

    function automatic logic [63:0] mkp(int wc, bit wo, int sc, bit so, int tsa);
        return {wc[14:0], wo, sc[14:0], so, 15'b0, tsa[16:0]};
    endfunction

    always @(negedge clk) rdy_tog <= ~rdy_tog;

    // memory and register-file models, event counters
    always @(posedge clk) begin
        if (fill_en)
            for (int i = 0; i < 32; i++) rf[i] <= fval(i, fill_seed);
        if (!rst) begin
            if (mem_req && mem_ready) begin
                acc_addr[n_acc % 64] <= int'(mem_addr);
                if (mem_we) mem[mem_addr[8:0]] <= mem_wdata;
                n_acc <= n_acc + 1;
            end
            if (rf_we) begin
                rf[rf_idx] <= rf_wdata;
                n_rfw <= n_rfw + 1;
            end
            if (done)        n_done <= n_done + 1;
            if (dflt_psw_ld) n_dflt <= n_dflt + 1;
            if (trap_req)    n_trap <= n_trap + 1;
            if (cc2_set)     n_cc2  <= n_cc2 + 1;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_dw(input logic [63:0] v);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic fill(input logic [23:0] s);
        @(negedge clk);
        fill_seed = s;
        fill_en = 1'b1;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    task automatic op(input bit is_push, input bit poke);
        int d0 = n_done;
        @(negedge clk);
        push_go = is_push;
        pull_go = !is_push;
        @(negedge clk);
        push_go = 1'b0;
        pull_go = 1'b0;
        for (int i = 0; i < 400; i++) begin
            if (n_done != d0) break;
            wr_en = poke && (i == 4);
            wr_data = '1;
            @(negedge clk);
        end
        wr_en = 1'b0;
    endtask

    task automatic roundtrip(input int tsa, input int wc, input int sc, input bit stall_v, input logic [23:0] seed);
        int a0, r0, d0, bad;
        stall = stall_v;
        wr_dw(mkp(wc, 0, sc, 0, tsa));
        fill(seed);
        a0 = n_acc; d0 = n_done;
        op(1'b1, 1'b0);
        chk("R2 save access count", 64'(n_acc - a0), 64'd28);
        chk("R10 one done per save", 64'(n_done - d0), 64'd1);
        bad = 0;
        for (int k = 0; k < 28; k++)
            if (acc_addr[(a0 + k) % 64] != ((tsa + 1 + k) & AMASK)) bad++;
        chk("R2 ascending addresses", 64'(bad), 64'd0);
        bad = 0;
        for (int j = 0; j < 28; j++) begin
            logic [31:0] e;
            e = BMASK[j] ? fval(bslot(j), seed) : 32'h0;
            if (mem[(tsa + 1 + j) & 511] !== e) bad++;
        end
        chk("R3 saved words by position", 64'(bad), 64'd0);
        chk("R4 pointer after save", ptr_q,
            mkp((wc + 28) & 32767, (wc + 28) > 32767, (sc - 28) & 32767, 0, (tsa + 28) & AMASK));
        chk("R10 idle after save", {63'b0, busy}, 64'd0);
        fill(seed ^ 24'h5A5A5A);
        a0 = n_acc; r0 = n_rfw;
        op(1'b0, 1'b0);
        chk("R5 restore access count", 64'(n_acc - a0), 64'd28);
        chk("R5 register writes", 64'(n_rfw - r0), 64'd20);
        bad = 0;
        for (int k = 0; k < 28; k++)
            if (acc_addr[(a0 + k) % 64] != ((tsa + 28 - k) & AMASK)) bad++;
        chk("R5 descending addresses", 64'(bad), 64'd0);
        bad = 0;
        for (int i = 0; i < 20; i++)
            if (rf[i] !== fval(i, seed)) bad++;
        chk("R5 registers restored", 64'(bad), 64'd0);
        chk("R6 pointer after restore", ptr_q, mkp(wc, 0, sc, 0, tsa));
    endtask

    task automatic run_all();
        int a0, t0, c0, f0, d0;
        logic [63:0] p0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R11 pointer after reset", ptr_q, 64'd0);
        chk("R11 idle after reset", {62'b0, busy, mem_req}, 64'd0);

        wr_dw(64'h1234_5678_9ABC_DEF0);
        chk("R1 direct write all bits", ptr_q, 64'h1234_5678_9ABC_DEF0);

        roundtrip(5, 40, 1000, 0, 24'h111111);
        roundtrip(200, 100, 500, 1, 24'h222222);
        roundtrip(32'h1FFF0, 28, 28, 0, 24'h333333);
        roundtrip(32'h1FFFF, 3000, 20000, 1, 24'h444444);

        // word overflow on save, then trap on restore
        stall = 1'b0;
        wr_dw(mkp(32762, 0, 500, 0, 1000));
        fill(24'h555555);
        op(1'b1, 1'b0);
        chk("R4 word count wraps and flags", ptr_q, mkp(22, 1, 472, 0, 1028));
        p0 = ptr_q; a0 = n_acc; t0 = n_trap; c0 = n_cc2; d0 = n_done;
        op(1'b0, 1'b0);
        chk("R9 trap pulse", 64'(n_trap - t0), 64'd1);
        chk("R9 cc2 pulse", 64'(n_cc2 - c0), 64'd1);
        chk("R9 no access on trap", 64'(n_acc - a0), 64'd0);
        chk("R9 pointer unchanged", ptr_q, p0);
        chk("R9 trap vector", 64'(trap_vec), 64'h4D);
        chk("R9 done on trap", 64'(n_done - d0), 64'd1);

        // sticky flags and space overflow on restore
        wr_dw(mkp(100, 1, 32760, 0, 2000));
        op(1'b0, 1'b0);
        chk("R6 space wraps and flags, R7 word flag kept", ptr_q, mkp(72, 1, 20, 1, 1972));
        a0 = n_acc; t0 = n_trap;
        op(1'b1, 1'b0);
        chk("R7 space flag kept through save", 64'(ptr_q[32]), 64'd1);
        chk("R4 save runs through zero space", 64'(n_acc - a0), 64'd28);
        chk("R4 no trap on save", 64'(n_trap - t0), 64'd0);
        wr_dw(mkp(40, 0, 100, 0, 3000));
        chk("R7 direct write clears flags", ptr_q, mkp(40, 0, 100, 0, 3000));

        // write during a walk is ignored
        wr_dw(mkp(50, 0, 300, 0, 600));
        op(1'b1, 1'b1);
        chk("R1 write ignored while busy", ptr_q, mkp(78, 0, 272, 0, 628));

        // restore gating sweep
        for (int wc = 0; wc <= 30; wc++) begin
            wr_dw(mkp(wc, 0, 700, 0, 4000));
            a0 = n_acc; t0 = n_trap; f0 = n_dflt;
            op(1'b0, 1'b0);
            if (wc == 0) begin
                chk("R8 default load pulse", 64'(n_dflt - f0), 64'd1);
                chk("R8 no access", 64'(n_acc - a0 + n_trap - t0), 64'd0);
                chk("R8 pointer unchanged", ptr_q, mkp(0, 0, 700, 0, 4000));
            end else if (wc < 28) begin
                chk("R9 sweep trap", 64'(n_trap - t0), 64'd1);
                chk("R9 sweep no access", 64'(n_acc - a0 + n_dflt - f0), 64'd0);
                chk("R9 sweep pointer unchanged", ptr_q, mkp(wc, 0, 700, 0, 4000));
            end else begin
                chk("R5 sweep reads", 64'(n_acc - a0), 64'd28);
                chk("R6 sweep pointer", ptr_q, mkp(wc - 28, 0, 728, 0, 3972));
            end
        end
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                wd = 1;
            end
        join_any
        disable fork;
        if (wd) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=hung expected=finished");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule